// File: doc/BRIEF.md
# UART Channel Test-Mode Router

This block sits between the serial engines of a UART channel (a transmitter and a receiver, each with its own bit-clock enable) and the two serial pins. It selects one of four channel modes. In normal operation each engine runs on its own. In automatic echo, the incoming line is sent back out. In local loopback, the transmitter talks to its own receiver inside the chip. In remote loopback, the incoming line is forwarded out while the receiver sits idle.

For the chosen mode the router steers the serial paths and selects the bit-clock enable that drives each engine. It masks the status flags that the CPU must not see. It gates the CPU strobes that load the transmit holding register and unload the receive holding register. It also tells the receiver whether to check parity.

The incoming pin passes through a two-flop synchronizer. The outgoing pin is registered, so pin-to-pin forwarding costs three system clocks. A change of mode waits until both engines report idle. The outgoing line marks (stays high) while the change is pending. Baud generation and FIFOs live elsewhere.

Top module: `uart_mode_router`

## Requirements
- R1: After reset the active mode is normal (code 00 on `mode_active`) and `txd_pin` is high. Mode codes are 00 normal, 01 automatic echo, 10 local loopback, 11 remote loopback.
- R2: In normal mode, `txd_pin` equals `tx_ser` one clock later, and `rx_ser_in` equals `rxd_pin` two clocks later. `tx_clk_en` follows `tx_bclk_en` and `rx_clk_en` follows `rx_bclk_en`. All status flags, both CPU strobes and `rx_par_chk` (high) pass unchanged.
- R3: In automatic echo mode, `txd_pin` reproduces `rxd_pin` bit by bit three clocks later. This includes a held-low break, which is echoed until the line returns high. `rx_clk_en` follows `rx_bclk_en` and `tx_clk_en` is 0.
- R4: In automatic echo mode, `tx_rdy` and `tx_emp` read 0 and `tx_load` stays 0. `rx_unload`, `rx_rdy` and `rx_err` still pass, and `rx_par_chk` is 1.
- R5: In local loopback mode, `rx_ser_in` equals `tx_ser` in the same cycle and `rxd_pin` has no effect. `txd_pin` is held high. Both `tx_clk_en` and `rx_clk_en` follow `tx_bclk_en`, and the CPU strobes and status pass.
- R6: In remote loopback mode, `txd_pin` reproduces `rxd_pin` three clocks later. `tx_clk_en` follows `rx_bclk_en` and `rx_clk_en` is 0. `tx_load`, `rx_unload`, `rx_rdy`, `rx_err`, `tx_rdy`, `tx_emp` and `rx_par_chk` are all 0.
- R7: A requested mode becomes active only at a clock edge where `tx_idle` and `rx_idle` are both 1. While a request is pending, `txd_pin` is high and `tx_load` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 2 | Requested channel mode |
| rxd_pin | input | 1 | Serial receive pin (asynchronous) |
| tx_ser | input | 1 | Serial output of the transmitter engine |
| tx_idle | input | 1 | Transmitter engine has no frame in progress |
| rx_idle | input | 1 | Receiver engine has no frame in progress |
| tx_bclk_en | input | 1 | Transmit-side bit-clock enable |
| rx_bclk_en | input | 1 | Receive-side bit-clock enable |
| cpu_wr_thr | input | 1 | CPU write strobe to the transmit holding register |
| cpu_rd_rhr | input | 1 | CPU read strobe from the receive holding register |
| tx_rdy_raw | input | 1 | Transmitter ready, from the engine |
| tx_emp_raw | input | 1 | Transmitter empty, from the engine |
| rx_rdy_raw | input | 1 | Receiver has data, from the engine |
| rx_err_raw | input | ERR_W | Receive error flags (parity, framing, break) |
| txd_pin | output | 1 | Serial transmit pin (registered) |
| rx_ser_in | output | 1 | Serial input to the receiver engine |
| tx_clk_en | output | 1 | Bit-clock enable for the transmitter engine |
| rx_clk_en | output | 1 | Bit-clock enable for the receiver engine |
| tx_load | output | 1 | Gated transmit holding register write |
| rx_unload | output | 1 | Gated receive holding register read |
| tx_rdy | output | 1 | Masked transmitter ready |
| tx_emp | output | 1 | Masked transmitter empty |
| rx_rdy | output | 1 | Masked receiver ready |
| rx_err | output | ERR_W | Masked receive error flags |
| rx_par_chk | output | 1 | Parity check enable for the receiver |
| mode_active | output | 2 | Mode currently in force |

## Verification
Normal mode is driven with an irregular transmitter bit pattern, which shows that the output path takes data from the engine with a one-cycle latency. Echo and remote loopback are driven with an irregular pin pattern that contains a long low run. This shows the three-cycle forwarding, and that a break is carried through instead of being cut short. In local loopback the pin is toggled against the transmitter in opposite phase, so any leak from the pin into the receiver would show. A mode request made while an engine is busy, with the pin held low, tells apart a switch that waits for idle and keeps the line marking from one that changes mode at once.

// File: rtl/uart_route_pkg.sv
// Shared types for the UART channel test-mode router.
// Assumes the 2-bit mode encoding is fixed by the register that feeds it.
package uart_route_pkg;
    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_ECHO   = 2'b01,
        CH_LOCAL  = 2'b10,
        CH_REMOTE = 2'b11
    } ch_mode_e;
endpackage

// File: rtl/uart_route_sync.sv
// Multi-flop synchronizer for the asynchronous receive pin.
// Assumes the line idles high, so every stage resets to 1.
module uart_route_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single stage: capture the pin directly.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            // Shift the pin through the chain, one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_route_modectl.sv
// Holds the active channel mode and applies a new request only when
// both engines report idle. Flags a pending change so the output can mark.
// Assumes tx_idle/rx_idle are registered signals from the engines.
module uart_route_modectl
    import uart_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic [1:0] mode_req,
    input  logic     tx_idle,
    input  logic     rx_idle,
    output ch_mode_e mode_act,
    output logic     switching
);
    logic both_idle;

    assign both_idle = tx_idle && rx_idle;
    assign switching = (mode_req != mode_act);

    // Latch the requested mode at the first edge where both engines idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      mode_act <= CH_NORMAL;
        else if (switching && both_idle) mode_act <= ch_mode_e'(mode_req);
    end

    // R7: a pending request must not take effect while an engine is busy.
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (switching && !both_idle) |=> $stable(mode_act));

    // R7: once both engines idle, the request is in force next cycle.
    a_r7_apply_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (switching && both_idle) |=> (mode_act == $past(mode_req)));
endmodule

// File: rtl/uart_route_path.sv
// Serial data steering and bit-clock enable selection for each mode.
// The transmit pin is registered; the receiver input is combinational.
// Assumes rxd_s is already synchronized to clk.
module uart_route_path
    import uart_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ch_mode_e mode_act,
    input  logic     switching,
    input  logic     rxd_s,
    input  logic     tx_ser,
    input  logic     tx_bclk_en,
    input  logic     rx_bclk_en,
    output logic     txd_pin,
    output logic     rx_ser_in,
    output logic     tx_clk_en,
    output logic     rx_clk_en
);
    logic txd_d;

    // Choose the next value of the transmit pin.
    always_comb begin
        if (switching) txd_d = 1'b1;
        else begin
            unique case (mode_act)
                CH_NORMAL: txd_d = tx_ser;
                CH_ECHO:   txd_d = rxd_s;
                CH_LOCAL:  txd_d = 1'b1;
                CH_REMOTE: txd_d = rxd_s;
                default:   txd_d = 1'b1;
            endcase
        end
    end

    // Register the pin so it is glitch-free and one cycle behind its source.
    always_ff @(posedge clk) begin
        if (!rst_n) txd_pin <= 1'b1;
        else        txd_pin <= txd_d;
    end

    // Feed the receiver engine and route the bit-clock enables.
    always_comb begin
        unique case (mode_act)
            CH_NORMAL: begin rx_ser_in = rxd_s;  tx_clk_en = tx_bclk_en; rx_clk_en = rx_bclk_en; end
            CH_ECHO:   begin rx_ser_in = rxd_s;  tx_clk_en = 1'b0;       rx_clk_en = rx_bclk_en; end
            CH_LOCAL:  begin rx_ser_in = tx_ser; tx_clk_en = tx_bclk_en; rx_clk_en = tx_bclk_en; end
            CH_REMOTE: begin rx_ser_in = 1'b1;   tx_clk_en = rx_bclk_en; rx_clk_en = 1'b0;       end
            default:   begin rx_ser_in = 1'b1;   tx_clk_en = 1'b0;       rx_clk_en = 1'b0;       end
        endcase
    end

    // R5: local loopback or a pending switch leaves the line marking.
    a_r5_txd_marks: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_act == CH_LOCAL) || switching) |=> txd_pin);

    // R3: echo forwards the synchronized pin with one cycle of delay.
    a_r3_echo_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_act == CH_ECHO) && !switching) |=> (txd_pin == $past(rxd_s)));

    // R6: remote loopback forwards the synchronized pin the same way.
    a_r6_remote_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_act == CH_REMOTE) && !switching) |=> (txd_pin == $past(rxd_s)));

    // R2: normal mode drives the pin from the transmitter engine.
    a_r2_normal_txd: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_act == CH_NORMAL) && !switching) |=> (txd_pin == $past(tx_ser)));
endmodule

// File: rtl/uart_route_gate.sv
// Masks CPU strobes and engine status according to the active mode.
// Assumes strobes are single-cycle pulses from the register interface.
module uart_route_gate
    import uart_route_pkg::*;
#(
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_mode_e         mode_act,
    input  logic             switching,
    input  logic             cpu_wr_thr,
    input  logic             cpu_rd_rhr,
    input  logic             tx_rdy_raw,
    input  logic             tx_emp_raw,
    input  logic             rx_rdy_raw,
    input  logic [ERR_W-1:0] rx_err_raw,
    output logic             tx_load,
    output logic             rx_unload,
    output logic             tx_rdy,
    output logic             tx_emp,
    output logic             rx_rdy,
    output logic [ERR_W-1:0] rx_err,
    output logic             rx_par_chk
);
    logic tx_open;
    logic rx_open;

    // Decide which CPU sides are reachable in this mode.
    always_comb begin
        tx_open = (mode_act == CH_NORMAL) || (mode_act == CH_LOCAL);
        rx_open = (mode_act != CH_REMOTE);
    end

    // Apply the masks to strobes, status and the parity check enable.
    always_comb begin
        tx_load    = cpu_wr_thr && tx_open && !switching;
        tx_rdy     = tx_rdy_raw && tx_open;
        tx_emp     = tx_emp_raw && tx_open;
        rx_unload  = cpu_rd_rhr && rx_open;
        rx_rdy     = rx_rdy_raw && rx_open;
        rx_err     = rx_open ? rx_err_raw : '0;
        rx_par_chk = rx_open;
    end

    // R4/R6: the CPU can never load the transmitter in echo or remote mode.
    a_r4_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_act == CH_ECHO) || (mode_act == CH_REMOTE)) |-> !tx_load);

    // R6: remote loopback keeps every receive status quiet.
    a_r6_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == CH_REMOTE) |-> (!rx_rdy && (rx_err == '0) && !rx_unload && !rx_par_chk));
endmodule

// File: rtl/uart_mode_router.sv
// Top of the UART channel test-mode router: synchronizes the receive pin,
// tracks the active mode, steers the serial paths and masks CPU-side signals.
// Assumes the engines signal idle between frames.
module uart_mode_router
    import uart_route_pkg::*;
#(
    parameter int ERR_W     = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_req,
    input  logic             rxd_pin,
    input  logic             tx_ser,
    input  logic             tx_idle,
    input  logic             rx_idle,
    input  logic             tx_bclk_en,
    input  logic             rx_bclk_en,
    input  logic             cpu_wr_thr,
    input  logic             cpu_rd_rhr,
    input  logic             tx_rdy_raw,
    input  logic             tx_emp_raw,
    input  logic             rx_rdy_raw,
    input  logic [ERR_W-1:0] rx_err_raw,
    output logic             txd_pin,
    output logic             rx_ser_in,
    output logic             tx_clk_en,
    output logic             rx_clk_en,
    output logic             tx_load,
    output logic             rx_unload,
    output logic             tx_rdy,
    output logic             tx_emp,
    output logic             rx_rdy,
    output logic [ERR_W-1:0] rx_err,
    output logic             rx_par_chk,
    output logic [1:0]       mode_active
);
    ch_mode_e mode_act;
    logic     switching;
    logic     rxd_s;

    uart_route_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(rxd_pin), .sync_out(rxd_s)
    );

    uart_route_modectl u_modectl (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
        .tx_idle(tx_idle), .rx_idle(rx_idle),
        .mode_act(mode_act), .switching(switching)
    );

    uart_route_path u_path (
        .clk(clk), .rst_n(rst_n), .mode_act(mode_act), .switching(switching),
        .rxd_s(rxd_s), .tx_ser(tx_ser),
        .tx_bclk_en(tx_bclk_en), .rx_bclk_en(rx_bclk_en),
        .txd_pin(txd_pin), .rx_ser_in(rx_ser_in),
        .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en)
    );

    uart_route_gate #(.ERR_W(ERR_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .mode_act(mode_act), .switching(switching),
        .cpu_wr_thr(cpu_wr_thr), .cpu_rd_rhr(cpu_rd_rhr),
        .tx_rdy_raw(tx_rdy_raw), .tx_emp_raw(tx_emp_raw),
        .rx_rdy_raw(rx_rdy_raw), .rx_err_raw(rx_err_raw),
        .tx_load(tx_load), .rx_unload(rx_unload),
        .tx_rdy(tx_rdy), .tx_emp(tx_emp), .rx_rdy(rx_rdy),
        .rx_err(rx_err), .rx_par_chk(rx_par_chk)
    );

    assign mode_active = mode_act;

    // R5: in local loopback the receiver hears the transmitter, not the pin.
    a_r5_loop_feed: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == CH_LOCAL) |-> (rx_ser_in == tx_ser));

    // R4: echo hides transmitter status from the CPU.
    a_r4_tx_status_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == CH_ECHO) |-> (!tx_rdy && !tx_emp && !tx_clk_en));
endmodule

// File: tb/uart_mode_router_test.sv
module uart_mode_router_test;
    localparam int ERR_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_req = 2'b00;
    logic             rxd_pin = 1'b1;
    logic             tx_ser = 1'b1;
    logic             tx_idle = 1'b1;
    logic             rx_idle = 1'b1;
    logic             tx_bclk_en = 1'b0;
    logic             rx_bclk_en = 1'b0;
    logic             cpu_wr_thr = 1'b0;
    logic             cpu_rd_rhr = 1'b0;
    logic             tx_rdy_raw = 1'b0;
    logic             tx_emp_raw = 1'b0;
    logic             rx_rdy_raw = 1'b0;
    logic [ERR_W-1:0] rx_err_raw = '0;
    logic             txd_pin, rx_ser_in, tx_clk_en, rx_clk_en;
    logic             tx_load, rx_unload, tx_rdy, tx_emp, rx_rdy, rx_par_chk;
    logic [ERR_W-1:0] rx_err;
    logic [1:0]       mode_active;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Scoreboard state: expected txd bits and the pipeline depth to apply.
    logic exp_q[$];
    int   lat = 1;
    bit   mon_on = 0;
    string mon_req = "R2";

    always #4 clk = ~clk; // 125 MHz

    uart_mode_router #(.ERR_W(ERR_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .rxd_pin(rxd_pin),
        .tx_ser(tx_ser), .tx_idle(tx_idle), .rx_idle(rx_idle),
        .tx_bclk_en(tx_bclk_en), .rx_bclk_en(rx_bclk_en),
        .cpu_wr_thr(cpu_wr_thr), .cpu_rd_rhr(cpu_rd_rhr),
        .tx_rdy_raw(tx_rdy_raw), .tx_emp_raw(tx_emp_raw),
        .rx_rdy_raw(rx_rdy_raw), .rx_err_raw(rx_err_raw),
        .txd_pin(txd_pin), .rx_ser_in(rx_ser_in),
        .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en),
        .tx_load(tx_load), .rx_unload(rx_unload),
        .tx_rdy(tx_rdy), .tx_emp(tx_emp), .rx_rdy(rx_rdy),
        .rx_err(rx_err), .rx_par_chk(rx_par_chk), .mode_active(mode_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Monitor: after each edge, pop the item whose latency has elapsed.
    always @(posedge clk) begin
        #2;
        if (mon_on && exp_q.size() >= lat) begin
            logic e;
            e = exp_q.pop_front();
            chk_eq(mon_req, int'(txd_pin), int'(e));
        end
    end

    // Driver: apply one serial bit at a falling edge and record its echo.
    task automatic drive_bit(input bit from_pin, input logic b);
        @(negedge clk);
        if (from_pin) rxd_pin = b; else tx_ser = b;
        exp_q.push_back(b);
    endtask

    task automatic run_stream(input bit from_pin, input int depth, input string req,
                              input logic [31:0] pat, input int nbits);
        lat = depth; mon_req = req; exp_q.delete(); mon_on = 1;
        for (int i = 0; i < nbits; i++) drive_bit(from_pin, pat[i]);
        for (int i = 0; i < depth; i++) drive_bit(from_pin, 1'b1);
        @(negedge clk); @(negedge clk);
        mon_on = 0;
        exp_q.delete();
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_req = m;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk_eq("R1", mode_active, 0);
        chk_eq("R1", txd_pin, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: normal mode, transmitter pattern to the pin, one-cycle latency.
        run_stream(1'b0, 1, "R2", 32'b0110_1001_1100_0101_1011, 20);
        @(negedge clk); rxd_pin = 1'b0;
        @(negedge clk); @(negedge clk);
        chk_eq("R2", rx_ser_in, 0);
        rxd_pin = 1'b1;
        tx_bclk_en = 1; rx_bclk_en = 0; tx_rdy_raw = 1; tx_emp_raw = 1;
        rx_rdy_raw = 1; rx_err_raw = 3'b101; cpu_wr_thr = 1; cpu_rd_rhr = 1;
        #1;
        chk_eq("R2", {tx_clk_en, rx_clk_en}, 2'b10);
        chk_eq("R2", {tx_load, rx_unload, tx_rdy, tx_emp, rx_rdy, rx_par_chk}, 6'b111111);
        chk_eq("R2", rx_err, 3'b101);

        // R3/R4: automatic echo, pattern with a long break.
        cpu_wr_thr = 0; cpu_rd_rhr = 0;
        set_mode(2'b01);
        chk_eq("R3", mode_active, 1);
        run_stream(1'b1, 3, "R3", 32'b1011_0000_0000_0000_1101, 20);
        tx_bclk_en = 0; rx_bclk_en = 1; cpu_wr_thr = 1; cpu_rd_rhr = 1;
        #1;
        chk_eq("R3", {tx_clk_en, rx_clk_en}, 2'b01);
        chk_eq("R4", {tx_load, tx_rdy, tx_emp}, 3'b000);
        chk_eq("R4", {rx_unload, rx_rdy, rx_par_chk}, 3'b111);
        chk_eq("R4", rx_err, 3'b101);
        cpu_wr_thr = 0; cpu_rd_rhr = 0;

        // R5: local loopback, pin toggled opposite to the transmitter.
        set_mode(2'b10);
        chk_eq("R5", mode_active, 2);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            tx_ser = i[0]; rxd_pin = ~i[0];
            #1;
            chk_eq("R5", rx_ser_in, int'(tx_ser));
            chk_eq("R5", txd_pin, 1);
        end
        tx_ser = 1; rxd_pin = 1;
        tx_bclk_en = 1; rx_bclk_en = 0; cpu_wr_thr = 1; cpu_rd_rhr = 1;
        #1;
        chk_eq("R5", {tx_clk_en, rx_clk_en}, 2'b11);
        chk_eq("R5", {tx_load, rx_unload, tx_rdy, rx_rdy}, 4'b1111);
        cpu_wr_thr = 0; cpu_rd_rhr = 0;

        // R6: remote loopback forwarding and status suppression.
        set_mode(2'b11);
        chk_eq("R6", mode_active, 3);
        run_stream(1'b1, 3, "R6", 32'b1100_1010_0000_0001_0110, 20);
        tx_bclk_en = 0; rx_bclk_en = 1; cpu_wr_thr = 1; cpu_rd_rhr = 1;
        #1;
        chk_eq("R6", {tx_clk_en, rx_clk_en}, 2'b10);
        chk_eq("R6", {tx_load, rx_unload, rx_rdy, tx_rdy, tx_emp, rx_par_chk}, 6'b000000);
        chk_eq("R6", rx_err, 0);
        cpu_wr_thr = 0; cpu_rd_rhr = 0;

        // R7: request normal while the transmitter is busy and the pin is low.
        @(negedge clk); tx_idle = 0; rxd_pin = 0; tx_ser = 0; mode_req = 2'b00;
        repeat (5) @(negedge clk);
        chk_eq("R7", mode_active, 3);
        chk_eq("R7", txd_pin, 1);
        cpu_wr_thr = 1; #1;
        chk_eq("R7", tx_load, 0);
        cpu_wr_thr = 0;
        tx_idle = 1;
        @(negedge clk);
        chk_eq("R7", mode_active, 0);
        @(negedge clk);
        chk_eq("R7", txd_pin, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule